// File: doc/BRIEF.md
# Interrupt Claim Arbitration Core

This block sits between level-sensitive interrupt sources and a set of target contexts. For every source it keeps whether the source is waiting (pending) and whether some context is servicing it (claimed). It also holds a registered copy of each source's priority, and of each context's enable mask and threshold. Each context has one request line. That line is high while at least one source qualifies for the context. A source qualifies when it is pending, not claimed, enabled for the context, and its priority is strictly above the context's threshold.

A context takes its interrupt by pulsing its claim strobe. The block picks the best qualifying source, returns its ID on a registered output and moves that source from pending to in-service in the same edge. When the handler is done, the context pulses its complete strobe with the source ID, and the source is released. Each source runs a four-state machine. The states are `SRC_IDLE` (neither pending nor claimed), `SRC_PEND` (pending only), `SRC_SERV` (claimed only) and `SRC_SERV_PEND` (claimed with its line high again). A grant takes `SRC_PEND` to `SRC_SERV`. A release takes `SRC_SERV`/`SRC_SERV_PEND` to `SRC_IDLE` or `SRC_PEND`, depending on the line. In the other states, the line level alone moves the machine between the idle/pending pair or the serviced pair.

Top module: `irq_claim_core`

## Requirements
- R1: The pending state of source i (i ≥ 1) is set at each clock edge where its line is high and cleared at an edge where the line is low. ID 0 is reserved: source 0 never becomes pending, and its line has no effect.
- R2: The request line of context c is high exactly when some source is pending, not claimed, has bit i of c's enable mask set, and has a priority above c's threshold. A source disabled for c does not affect c's line, even if it drives another context's line.
- R3: The priority comparison is strict. A priority equal to the threshold does not qualify, and a priority of 0 never qualifies.
- R4: On a claim, the winner is the qualifying source with the highest priority. Among equal priorities, the lowest ID wins. The ID appears on that context's claim_id slice after the clock edge and is held until the next claim.
- R5: The winning source has its pending state cleared and its claimed state set at the claim edge. While claimed, it does not raise any request line, even with its line still high.
- R6: A claim with no qualifying source returns ID 0 and changes no pending or claimed state.
- R7: A complete releases the claimed state of the given ID only when the ID is below the source count. Larger IDs are ignored, including IDs whose low bits alias a valid source.
- R8: Priorities, enables and thresholds are captured into registers at each edge. A configuration change affects the request lines from the edge after the change, not before it.
- R9: Claims from several contexts in one cycle are served from lowest context index upward. A higher context gets the best source not already taken by a lower one. A claim and a complete in the same cycle both take effect. A source claimed in the cycle in which it is also completed stays claimed.
- R10: A synchronous active-high reset clears pending and claimed state, priorities, enables, thresholds and the returned IDs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_line | input | NSRC | Level interrupt lines, bit i = source i (bit 0 unused) |
| src_prio | input | NSRC*3 | Priority of source i in bits [3i+2:3i] |
| ctx_en | input | NCTX*NSRC | Enable of source i for context c at bit c*NSRC+i |
| ctx_thr | input | NCTX*3 | Threshold of context c in bits [3c+2:3c] |
| claim_req | input | NCTX | One-cycle claim strobe per context |
| cmp_req | input | NCTX | One-cycle complete strobe per context |
| cmp_id | input | NCTX*IDW | Source ID being completed by context c |
| irq_req | output | NCTX | Request line per context |
| claim_id | output | NCTX*IDW | Last claimed ID per context, 0 when none |

## Verification
The bench goes after ordering and release edges. It checks that equal priorities resolve to the lower ID and that a lower-ID, lower-priority source loses. A design using `>=` would either pick the later tie or let a priority that only equals the threshold through. It completes ID 38, which aliases source 6 when truncated to five bits. A design that ignores the range check releases source 6 and raises a request that should stay low. It also issues a claim and a complete in the same cycle, on the same source and on different sources, and claims from both contexts at once. A design with no priority between contexts would hand one source to both of them. A design where release beats grant would leave the source free. Finally, it samples the request line just before and just after a threshold write, which exposes a design that reacts to configuration one cycle early.

// File: rtl/irq_claim_pkg.sv
package irq_claim_pkg;

    localparam int PRIO_W = 3;

    // Bit 1 = claimed, bit 0 = pending.
    typedef enum logic [1:0] {
        SRC_IDLE      = 2'b00,
        SRC_PEND      = 2'b01,
        SRC_SERV      = 2'b10,
        SRC_SERV_PEND = 2'b11
    } src_state_e;

endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
    import irq_claim_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    input  logic grab_i,
    input  logic rel_i,
    output logic pending_o,
    output logic claimed_o
);

    src_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= SRC_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRC_IDLE:      state_d = line_i ? SRC_PEND : SRC_IDLE;
            SRC_PEND: begin
                if (grab_i)      state_d = SRC_SERV;
                else if (line_i) state_d = SRC_PEND;
                else             state_d = SRC_IDLE;
            end
            SRC_SERV, SRC_SERV_PEND: begin
                if (rel_i) state_d = line_i ? SRC_PEND : SRC_IDLE;
                else       state_d = line_i ? SRC_SERV_PEND : SRC_SERV;
            end
            default:       state_d = SRC_IDLE;
        endcase
    end

    always_comb begin
        pending_o = 1'b0;
        claimed_o = 1'b0;
        unique case (state_q)
            SRC_IDLE:      ;
            SRC_PEND:      pending_o = 1'b1;
            SRC_SERV:      claimed_o = 1'b1;
            SRC_SERV_PEND: begin pending_o = 1'b1; claimed_o = 1'b1; end
            default:       ;
        endcase
    end

    // R5: a grant leaves the source claimed and no longer pending
    assert_grab_moves_R5: assert property (@(posedge clk) disable iff (rst)
        grab_i |=> (claimed_o && !pending_o));

    // R5: the claimed state only ever appears through a grant
    assert_claim_via_grab_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(claimed_o) |-> $past(grab_i));

endmodule

// File: rtl/irq_ctx_arb.sv
module irq_ctx_arb
    import irq_claim_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int IDW  = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NSRC-1:0]          pending_i,
    input  logic [NSRC-1:0]          claimed_i,
    input  logic [NSRC-1:0]          taken_i,
    input  logic [NSRC-1:0]          en_i,
    input  logic [NSRC*PRIO_W-1:0]   prio_i,
    input  logic [PRIO_W-1:0]        thr_i,
    output logic                     req_o,
    output logic [IDW-1:0]           win_id_o,
    output logic [NSRC-1:0]          win_vec_o
);

    localparam int SW = $clog2(NSRC);

    logic [NSRC-1:0] avail;
    logic [NSRC-1:0] above;

    genvar gi;
    generate
        for (gi = 0; gi < NSRC; gi++) begin : g_cmp
            assign above[gi] = prio_i[gi*PRIO_W +: PRIO_W] > thr_i;
        end
    endgenerate

    assign avail = pending_i & ~claimed_i & en_i;
    assign req_o = |(avail & above);

    // Ascending scan: a strictly larger priority replaces the best so far.
    always_comb begin
        logic [PRIO_W-1:0] best;
        best      = thr_i;
        win_id_o  = '0;
        win_vec_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (avail[i] && !taken_i[i] && (prio_i[i*PRIO_W +: PRIO_W] > best)) begin
                best      = prio_i[i*PRIO_W +: PRIO_W];
                win_id_o  = IDW'(i);
                win_vec_o = '0;
                win_vec_o[i] = 1'b1;
            end
        end
    end

    // R3: any winner lies strictly above the threshold
    assert_win_above_thr_R3: assert property (@(posedge clk) disable iff (rst)
        (win_id_o != '0) |-> (prio_i[win_id_o[SW-1:0]*PRIO_W +: PRIO_W] > thr_i));

    // R4: at most one source is selected per context
    assert_single_winner_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(win_vec_o));

    // R2: nothing can be selected while the request line is low
    assert_no_win_without_req_R2: assert property (@(posedge clk) disable iff (rst)
        !req_o |-> (win_id_o == '0));

endmodule

// File: rtl/irq_claim_core.sv
module irq_claim_core
    import irq_claim_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int NCTX = 2,
    parameter int IDW  = $clog2(NSRC) + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NSRC-1:0]          src_line,
    input  logic [NSRC*PRIO_W-1:0]   src_prio,
    input  logic [NCTX*NSRC-1:0]     ctx_en,
    input  logic [NCTX*PRIO_W-1:0]   ctx_thr,
    input  logic [NCTX-1:0]          claim_req,
    input  logic [NCTX-1:0]          cmp_req,
    input  logic [NCTX*IDW-1:0]      cmp_id,
    output logic [NCTX-1:0]          irq_req,
    output logic [NCTX*IDW-1:0]      claim_id
);

    localparam logic [NSRC-1:0] RSVD_MASK = NSRC'(1);

    logic [NSRC*PRIO_W-1:0] prio_q;
    logic [NCTX*NSRC-1:0]   en_q;
    logic [NCTX*PRIO_W-1:0] thr_q;
    logic [NCTX*IDW-1:0]    claim_id_q;

    logic [NSRC-1:0] eff_line;
    logic [NSRC-1:0] pending;
    logic [NSRC-1:0] claimed;
    logic [NSRC-1:0] rel_vec;
    logic [NSRC-1:0] taken   [NCTX+1];
    logic [NSRC-1:0] win_vec [NCTX];
    logic [IDW-1:0]  win_id  [NCTX];

    always_ff @(posedge clk) begin
        if (rst) begin
            prio_q <= '0;
            en_q   <= '0;
            thr_q  <= '0;
        end else begin
            prio_q <= src_prio;
            en_q   <= ctx_en;
            thr_q  <= ctx_thr;
        end
    end

    assign eff_line = src_line & ~RSVD_MASK;

    always_comb begin
        rel_vec = '0;
        for (int c = 0; c < NCTX; c++) begin
            if (cmp_req[c] && (cmp_id[c*IDW +: IDW] < IDW'(NSRC)))
                rel_vec = rel_vec | (NSRC'(1) << cmp_id[c*IDW +: IDW]);
        end
    end

    genvar gs, gc;
    generate
        for (gs = 0; gs < NSRC; gs++) begin : g_src
            irq_src_cell u_cell (
                .clk       (clk),
                .rst       (rst),
                .line_i    (eff_line[gs]),
                .grab_i    (taken[NCTX][gs]),
                .rel_i     (rel_vec[gs]),
                .pending_o (pending[gs]),
                .claimed_o (claimed[gs])
            );
        end

        assign taken[0] = '0;

        for (gc = 0; gc < NCTX; gc++) begin : g_ctx
            irq_ctx_arb #(.NSRC(NSRC), .IDW(IDW)) u_arb (
                .clk       (clk),
                .rst       (rst),
                .pending_i (pending),
                .claimed_i (claimed),
                .taken_i   (taken[gc]),
                .en_i      (en_q[gc*NSRC +: NSRC]),
                .prio_i    (prio_q),
                .thr_i     (thr_q[gc*PRIO_W +: PRIO_W]),
                .req_o     (irq_req[gc]),
                .win_id_o  (win_id[gc]),
                .win_vec_o (win_vec[gc])
            );

            assign taken[gc+1] = taken[gc] | (claim_req[gc] ? win_vec[gc] : '0);

            always_ff @(posedge clk) begin
                if (rst)                claim_id_q[gc*IDW +: IDW] <= '0;
                else if (claim_req[gc]) claim_id_q[gc*IDW +: IDW] <= win_id[gc];
            end

            // R6: an empty claim reports ID 0
            assert_empty_claim_R6: assert property (@(posedge clk) disable iff (rst)
                (claim_req[gc] && (win_id[gc] == '0)) |=> (claim_id[gc*IDW +: IDW] == '0));

            // R9: a context never picks a source a lower context already took
            assert_no_double_grant_R9: assert property (@(posedge clk) disable iff (rst)
                (win_vec[gc] & taken[gc]) == '0);
        end
    endgenerate

    assign claim_id = claim_id_q;

    // R1: the reserved source never becomes pending
    assert_rsvd_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !pending[0]);

endmodule

// File: tb/sim_irq_claim_core.sv
module sim_irq_claim_core;

    localparam int NSRC = 32;
    localparam int NCTX = 2;
    localparam int IDW  = 6;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [NSRC-1:0]      src_line = '0;
    logic [NSRC*3-1:0]    src_prio = '0;
    logic [NCTX*NSRC-1:0] ctx_en = '0;
    logic [NCTX*3-1:0]    ctx_thr = '0;
    logic [NCTX-1:0]      claim_req = '0;
    logic [NCTX-1:0]      cmp_req = '0;
    logic [NCTX*IDW-1:0]  cmp_id = '0;
    logic [NCTX-1:0]      irq_req;
    logic [NCTX*IDW-1:0]  claim_id;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    irq_claim_core #(.NSRC(NSRC), .NCTX(NCTX), .IDW(IDW)) u0 (
        .clk(clk), .rst(rst), .src_line(src_line), .src_prio(src_prio),
        .ctx_en(ctx_en), .ctx_thr(ctx_thr), .claim_req(claim_req),
        .cmp_req(cmp_req), .cmp_id(cmp_id), .irq_req(irq_req), .claim_id(claim_id)
    );

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        src_line = '0; src_prio = '0; ctx_en = '0; ctx_thr = '0;
        claim_req = '0; cmp_req = '0; cmp_id = '0;
        rst = 1'b1;
        step();
        rst = 1'b0;
    endtask

    task automatic set_src(int s, int p, bit lvl);
        src_prio[s*3 +: 3] = 3'(p);
        src_line[s] = lvl;
    endtask

    task automatic claim(int c);
        claim_req[c] = 1'b1;
        step();
        claim_req[c] = 1'b0;
    endtask

    task automatic complete(int c, int id);
        cmp_req[c] = 1'b1;
        cmp_id[c*IDW +: IDW] = IDW'(id);
        step();
        cmp_req[c] = 1'b0;
    endtask

    function automatic int cid(int c);
        return int'(claim_id[c*IDW +: IDW]);
    endfunction

    task automatic t_reset();
        do_reset();
        chk("R10 req after reset", int'(irq_req), 0);
        chk("R10 id0 after reset", cid(0), 0);
        chk("R10 id1 after reset", cid(1), 0);
    endtask

    task automatic t_level();
        do_reset();
        ctx_en[NSRC-1:0] = '1;
        set_src(3, 2, 1'b1);
        step();
        chk("R1 line high sets pending", int'(irq_req[0]), 1);
        src_line[3] = 1'b0;
        step();
        chk("R1 line low clears pending", int'(irq_req[0]), 0);
        set_src(0, 7, 1'b1);
        step();
        chk("R1 source 0 ignored", int'(irq_req[0]), 0);
        claim(0);
        chk("R1 source 0 not claimable", cid(0), 0);
    endtask

    task automatic t_thr();
        do_reset();
        ctx_en[5] = 1'b1;
        set_src(5, 2, 1'b1);
        ctx_thr[2:0] = 3'd2;
        step();
        chk("R3 equal to threshold", int'(irq_req[0]), 0);
        ctx_thr[2:0] = 3'd1;
        step();
        chk("R3 above threshold", int'(irq_req[0]), 1);
        set_src(5, 0, 1'b1);
        ctx_thr[2:0] = 3'd0;
        step();
        chk("R3 priority zero", int'(irq_req[0]), 0);
    endtask

    task automatic t_enable();
        do_reset();
        ctx_en[NSRC + 5] = 1'b1;
        set_src(5, 3, 1'b1);
        step();
        chk("R2 disabled context", int'(irq_req[0]), 0);
        chk("R2 enabled context", int'(irq_req[1]), 1);
    endtask

    task automatic t_claim_order();
        do_reset();
        ctx_en[NSRC-1:0] = '1;
        set_src(4, 3, 1'b1);
        set_src(6, 5, 1'b1);
        set_src(9, 5, 1'b1);
        step();
        claim(0);
        chk("R4 highest priority", cid(0), 6);
        chk("R2 still requesting", int'(irq_req[0]), 1);
        claim(0);
        chk("R4 tie to lower id", cid(0), 9);
        claim(0);
        chk("R4 lowest priority last", cid(0), 4);
        chk("R5 claimed sources silent", int'(irq_req[0]), 0);
        claim(0);
        chk("R6 empty claim id", cid(0), 0);
        complete(0, 6);
        chk("R7 release re-raises", int'(irq_req[0]), 1);
        claim(0);
        chk("R6 state kept after empty claim", cid(0), 6);
        claim(0);
        chk("R6 others still claimed", cid(0), 0);
    endtask

    task automatic t_range();
        do_reset();
        ctx_en[NSRC-1:0] = '1;
        set_src(6, 5, 1'b1);
        step();
        claim(0);
        chk("R7 claim setup", cid(0), 6);
        complete(0, 38);
        chk("R7 aliased id ignored", int'(irq_req[0]), 0);
        complete(0, 32);
        chk("R7 id equal to count ignored", int'(irq_req[0]), 0);
        complete(0, 6);
        chk("R7 valid id releases", int'(irq_req[0]), 1);
    endtask

    task automatic t_dual();
        do_reset();
        ctx_en = '1;
        set_src(4, 3, 1'b1);
        set_src(6, 5, 1'b1);
        step();
        claim_req = 2'b11;
        step();
        claim_req = '0;
        chk("R9 lower context first", cid(0), 6);
        chk("R9 higher context next best", cid(1), 4);
        chk("R5 both claimed", int'(irq_req), 0);
        // reset with inputs still driven: claimed state must be gone
        rst = 1'b1;
        step();
        rst = 1'b0;
        step();
        chk("R10 reset clears claimed", int'(irq_req), 3);
    endtask

    task automatic t_same_cycle();
        do_reset();
        ctx_en[NSRC-1:0] = '1;
        set_src(6, 5, 1'b1);
        step();
        claim_req[0] = 1'b1;
        cmp_req[1] = 1'b1;
        cmp_id[IDW +: IDW] = IDW'(6);
        step();
        claim_req = '0; cmp_req = '0;
        chk("R9 grant beats release id", cid(0), 6);
        chk("R9 grant beats release", int'(irq_req[0]), 0);
        set_src(4, 3, 1'b1);
        step();
        claim_req[0] = 1'b1;
        cmp_req[1] = 1'b1;
        cmp_id[IDW +: IDW] = IDW'(6);
        step();
        claim_req = '0; cmp_req = '0;
        chk("R9 claim applied", cid(0), 4);
        chk("R9 complete applied", int'(irq_req[0]), 1);
        claim(0);
        chk("R9 released source claimable", cid(0), 6);
    endtask

    task automatic t_cfg_delay();
        do_reset();
        ctx_en[NSRC-1:0] = '1;
        set_src(7, 4, 1'b1);
        step();
        chk("R8 setup", int'(irq_req[0]), 1);
        ctx_thr[2:0] = 3'd5;
        #1;
        chk("R8 no early effect", int'(irq_req[0]), 1);
        step();
        chk("R8 effect after edge", int'(irq_req[0]), 0);
    endtask

    initial begin
        t_reset();
        t_level();
        t_thr();
        t_enable();
        t_claim_order();
        t_range();
        t_dual();
        t_same_cycle();
        t_cfg_delay();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #100000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule